// File: doc/BRIEF.md
# Attribute Controller Palette Port

This block is the register port of a VGA-style attribute controller, together with a sixteen-entry colour palette. Software reaches it through three CPU strobes. The first is a write strobe on one shared address that serves both the index and the data register. The second is a data read strobe on a separate address. The third is the read strobe of the input status register. An internal toggle decides whether a shared-address write loads the index register or the data register that the index currently selects. Reading the status register puts the toggle back to the index side, which gives software a known starting point.

The index register has two parts. A 5-bit selector picks the data register. A source bit hands palette addressing either to the CPU or to the pixel stream. Each palette entry holds a 6-bit colour. On the display side, a 1-, 2- or 4-bit frame-buffer pixel is zero-extended to four bits and used as the palette address. The matching colour comes out one clock later for the DAC. While the source bit is set, CPU access to the palette is shut off: writes are dropped and reads return zero.

Top module: `attr_pal_port`

## Requirements
- R1: After reset, the toggle is on the index side. The selector, the source bit, every palette entry, `cpu_rdata` and `pix_color` are all zero.
- R2: A `stat_rd` pulse puts the toggle on the index side for the next cycle. A `cpu_wr` in the same cycle is still handled with the toggle state it had before the pulse.
- R3: Successive `cpu_wr` strobes alternate between the index register and the data register, starting from the index side.
- R4: An index write takes `cpu_wdata[4:0]` as the selector and `cpu_wdata[5]` as the palette source bit. Bits 7:6 are discarded.
- R5: A data write with source bit 0 and selector 0..15 stores `cpu_wdata[5:0]` into the selected entry. Bits 7:6 of the write data are dropped.
- R6: A data write with source bit 1 changes no palette entry, but it still moves the toggle back to the index side.
- R7: A `cpu_rd` strobe loads `cpu_rdata` on the next edge. The value is {2'b00, entry} when the source bit is 0 and the selector is 0..15, and zero otherwise. `cpu_rdata` holds between reads, and `cpu_rd` never moves the toggle.
- R8: Selectors 16..31 (bit 4 set) address no palette entry. Data writes to them change nothing, and reads return zero.
- R9: With the source bit at 1, `pix_color` shows, one cycle after `pix_val`, the entry addressed by the zero-extended pixel. `pix_mode` gives the pixel width: 00 means `pix_val[0]` only, 01 means `pix_val[1:0]`, and 10 or 11 means all four bits.
- R10: With the source bit at 0, `pix_color` shows, one cycle later, the entry addressed by selector bits 3:0, whatever the pixel input is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe for the shared index/data address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe for the data read address |
| stat_rd | input | 1 | Input status register read strobe (clears the toggle) |
| cpu_rdata | output | 8 | Registered read data |
| pix_mode | input | 2 | Pixel width: 00 = 1 bit, 01 = 2 bits, 1x = 4 bits |
| pix_val | input | 4 | Frame-buffer pixel value |
| pix_color | output | 6 | Registered palette colour for the DAC |

## Verification
The bench builds the block with its default parameters: 16 entries, 6-bit colours, a 5-bit selector and 4-bit pixels. At that size every palette entry can be written and read back with a distinct value. Every pixel value can be swept under all four width codes, with the expected colour worked out from a model of the palette kept in the bench. The small selector space also makes it practical to try the out-of-range selectors, the toggle behaviour when a status read and a write arrive in the same cycle, and the point where CPU access is handed over to the pixel stream.

// File: rtl/attr_pal_pkg.sv
package attr_pal_pkg;

    localparam int DATA_W    = 8;
    localparam int IDX_W     = 5;
    localparam int COLOR_W   = 6;
    localparam int PAL_AW    = 4;
    localparam int PAL_DEPTH = 1 << PAL_AW;
    localparam int PIX_W     = 4;

    typedef enum logic [1:0] {
        PIX_1B  = 2'b00,
        PIX_2B  = 2'b01,
        PIX_4B  = 2'b10,
        PIX_4BX = 2'b11
    } pix_width_e;

    typedef struct packed {
        logic              data_phase;
        logic              pal_src;
        logic [IDX_W-1:0]  sel;
        logic [DATA_W-1:0] rdata;
    } acc_state_t;

endpackage

// File: rtl/attr_access_ctl.sv
module attr_access_ctl
    import attr_pal_pkg::*;
#(
    parameter int D_W  = DATA_W,
    parameter int I_W  = IDX_W,
    parameter int C_W  = COLOR_W,
    parameter int A_W  = PAL_AW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_wr,
    input  logic [D_W-1:0] cpu_wdata,
    input  logic           cpu_rd,
    input  logic           stat_rd,
    input  logic [C_W-1:0] cpu_entry,
    output logic [A_W-1:0] cpu_addr,
    output logic           pal_we,
    output logic [C_W-1:0] pal_wdata,
    output logic           data_phase,
    output logic           pal_src,
    output logic [I_W-1:0] sel,
    output logic [D_W-1:0] cpu_rdata
);

    localparam int PAD_W = D_W - C_W;

    acc_state_t st_d, st_q;

    logic wr_index;
    logic wr_data;
    logic sel_in_range;
    logic cpu_ok;

    always_comb begin
        st_d         = st_q;
        wr_index     = cpu_wr && !st_q.data_phase;
        wr_data      = cpu_wr &&  st_q.data_phase;
        sel_in_range = (st_q.sel[I_W-1:A_W] == '0);
        cpu_ok       = !st_q.pal_src && sel_in_range;

        if (wr_index) begin
            st_d.sel     = cpu_wdata[I_W-1:0];
            st_d.pal_src = cpu_wdata[I_W];
        end

        if (cpu_wr) begin
            st_d.data_phase = !st_q.data_phase;
        end
        if (stat_rd) begin
            st_d.data_phase = 1'b0;
        end

        if (cpu_rd) begin
            if (cpu_ok) begin
                st_d.rdata = {{PAD_W{1'b0}}, cpu_entry};
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cpu_addr   = st_q.sel[A_W-1:0];
    assign pal_we     = wr_data && cpu_ok;
    assign pal_wdata  = cpu_wdata[C_W-1:0];
    assign data_phase = st_q.data_phase;
    assign pal_src    = st_q.pal_src;
    assign sel        = st_q.sel;
    assign cpu_rdata  = st_q.rdata;

endmodule

// File: rtl/attr_pal_store.sv
module attr_pal_store
    import attr_pal_pkg::*;
#(
    parameter int A_W = PAL_AW,
    parameter int C_W = COLOR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [A_W-1:0] waddr,
    input  logic [C_W-1:0] wdata,
    input  logic [A_W-1:0] cpu_raddr,
    output logic [C_W-1:0] cpu_rentry,
    input  logic [A_W-1:0] pix_raddr,
    output logic [C_W-1:0] pix_rentry
);

    localparam int DEPTH = 1 << A_W;

    logic [C_W-1:0] mem_d [DEPTH];
    logic [C_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (we) begin
            mem_d[waddr] = wdata;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_entry
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= '0;
                end else begin
                    mem_q[g] <= mem_d[g];
                end
            end
        end
    endgenerate

    assign cpu_rentry = mem_q[cpu_raddr];
    assign pix_rentry = mem_q[pix_raddr];

endmodule

// File: rtl/attr_pix_expand.sv
module attr_pix_expand
    import attr_pal_pkg::*;
#(
    parameter int P_W = PIX_W,
    parameter int A_W = PAL_AW,
    parameter int C_W = COLOR_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     pix_mode,
    input  logic [P_W-1:0] pix_val,
    input  logic           pal_src,
    input  logic [A_W-1:0] sel_lo,
    output logic [A_W-1:0] pix_addr,
    input  logic [C_W-1:0] pix_entry,
    output logic [C_W-1:0] pix_color
);

    logic [C_W-1:0] color_d, color_q;
    logic [P_W-1:0] width_mask;
    logic [P_W-1:0] pix_ext;
    int             active_bits;

    always_comb begin
        case (pix_width_e'(pix_mode))
            PIX_1B:  active_bits = 1;
            PIX_2B:  active_bits = 2;
            default: active_bits = P_W;
        endcase
        for (int b = 0; b < P_W; b++) begin
            width_mask[b] = (b < active_bits);
        end
        pix_ext = pix_val & width_mask;
    end

    generate
        if (P_W >= A_W) begin : g_pix_wide
            assign pix_addr = pal_src ? pix_ext[A_W-1:0] : sel_lo;
        end else begin : g_pix_narrow
            assign pix_addr = pal_src ? {{(A_W-P_W){1'b0}}, pix_ext} : sel_lo;
        end
    endgenerate

    always_comb begin
        color_d = pix_entry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            color_q <= '0;
        end else begin
            color_q <= color_d;
        end
    end

    assign pix_color = color_q;

endmodule

// File: rtl/attr_pal_port.sv
module attr_pal_port
    import attr_pal_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int I_W = IDX_W,
    parameter int C_W = COLOR_W,
    parameter int A_W = PAL_AW,
    parameter int P_W = PIX_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_wr,
    input  logic [D_W-1:0] cpu_wdata,
    input  logic           cpu_rd,
    input  logic           stat_rd,
    output logic [D_W-1:0] cpu_rdata,
    input  logic [1:0]     pix_mode,
    input  logic [P_W-1:0] pix_val,
    output logic [C_W-1:0] pix_color
);

    logic [A_W-1:0] cpu_addr_w;
    logic [C_W-1:0] cpu_entry_w;
    logic           pal_we_w;
    logic [C_W-1:0] pal_wdata_w;
    logic           data_phase_w;
    logic           pal_src_w;
    logic [I_W-1:0] sel_w;
    logic [A_W-1:0] pix_addr_w;
    logic [C_W-1:0] pix_entry_w;

    attr_access_ctl #(
        .D_W (D_W),
        .I_W (I_W),
        .C_W (C_W),
        .A_W (A_W)
    ) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_wr     (cpu_wr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .stat_rd    (stat_rd),
        .cpu_entry  (cpu_entry_w),
        .cpu_addr   (cpu_addr_w),
        .pal_we     (pal_we_w),
        .pal_wdata  (pal_wdata_w),
        .data_phase (data_phase_w),
        .pal_src    (pal_src_w),
        .sel        (sel_w),
        .cpu_rdata  (cpu_rdata)
    );

    attr_pal_store #(
        .A_W (A_W),
        .C_W (C_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (pal_we_w),
        .waddr      (cpu_addr_w),
        .wdata      (pal_wdata_w),
        .cpu_raddr  (cpu_addr_w),
        .cpu_rentry (cpu_entry_w),
        .pix_raddr  (pix_addr_w),
        .pix_rentry (pix_entry_w)
    );

    attr_pix_expand #(
        .P_W (P_W),
        .A_W (A_W),
        .C_W (C_W)
    ) u_pix (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_mode  (pix_mode),
        .pix_val   (pix_val),
        .pal_src   (pal_src_w),
        .sel_lo    (sel_w[A_W-1:0]),
        .pix_addr  (pix_addr_w),
        .pix_entry (pix_entry_w),
        .pix_color (pix_color)
    );

endmodule

// File: rtl/attr_pal_port_chk.sv
module attr_pal_port_chk
    import attr_pal_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int I_W = IDX_W,
    parameter int C_W = COLOR_W
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_wr,
    input logic [D_W-1:0] cpu_wdata,
    input logic           cpu_rd,
    input logic           stat_rd,
    input logic [D_W-1:0] cpu_rdata,
    input logic           data_phase,
    input logic           pal_src,
    input logic [I_W-1:0] sel
);

    AST_TOGGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> !data_phase); // R2

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !stat_rd) |=> (data_phase != $past(data_phase))); // R3

    AST_RD_NO_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_wr && !stat_rd) |=> $stable(data_phase)); // R7

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !data_phase) |=> (pal_src == $past(cpu_wdata[I_W]))); // R4

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdata[D_W-1:C_W] == '0); // R7

    AST_BLOCKED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && pal_src) |=> (cpu_rdata == '0)); // R7

    AST_RANGE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && sel[I_W-1]) |=> (cpu_rdata == '0)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |=> $stable(cpu_rdata)); // R7

endmodule

bind attr_pal_port attr_pal_port_chk #(
    .D_W (D_W),
    .I_W (I_W),
    .C_W (C_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .stat_rd    (stat_rd),
    .cpu_rdata  (cpu_rdata),
    .data_phase (data_phase_w),
    .pal_src    (pal_src_w),
    .sel        (sel_w)
);

// File: tb/attr_pal_port_bench.sv
module attr_pal_port_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic       cpu_rd = 1'b0;
    logic       stat_rd = 1'b0;
    logic [7:0] cpu_rdata;
    logic [1:0] pix_mode = 2'b10;
    logic [3:0] pix_val = '0;
    logic [5:0] pix_color;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [5:0] pal_m [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    attr_pal_port u_attr_pal_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_wr    (cpu_wr),
        .cpu_wdata (cpu_wdata),
        .cpu_rd    (cpu_rd),
        .stat_rd   (stat_rd),
        .cpu_rdata (cpu_rdata),
        .pix_mode  (pix_mode),
        .pix_val   (pix_val),
        .pix_color (pix_color)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input logic [7:0] d, input bit rd, input bit st);
        cpu_wr = wr; cpu_wdata = d; cpu_rd = rd; stat_rd = st;
        @(posedge clk);
        @(negedge clk);
        cpu_wr = 1'b0; cpu_rd = 1'b0; stat_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        cyc(1'b1, d, 1'b0, 1'b0);
    endtask

    task automatic stat();
        cyc(1'b0, 8'h00, 1'b0, 1'b1);
    endtask

    task automatic rd_check(input string req, input int exp);
        cyc(1'b0, 8'h00, 1'b1, 1'b0);
        check(req, cpu_rdata, exp);
    endtask

    function automatic int pix_exp(input int mode, input int v);
        if (mode == 0) return pal_m[v & 1];
        if (mode == 1) return pal_m[v & 3];
        return pal_m[v & 15];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) pal_m[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 rdata", cpu_rdata, 0);
        check("R1 pix", pix_color, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd_check("R1 entry0 after reset", 0);
        // R1: toggle on index side: first write is index 0x05, second data
        wr(8'h05); wr(8'h2A); pal_m[5] = 6'h2A;
        rd_check("R1 first write went to index", 8'h2A);

        // R5 / R3: fill all entries, upper data bits set to check stripping
        stat();
        for (int i = 0; i < 16; i++) begin
            pal_m[i] = 6'((i * 7 + 3) & 63);
            wr(8'(i));
            wr(8'({2'b11, pal_m[i]}));
        end
        for (int i = 0; i < 16; i++) begin
            stat();
            wr(8'(i));
            rd_check("R5 readback", {2'b00, pal_m[i]});
        end

        // R3: alternation without status reads
        stat();
        wr(8'h03); wr(8'h11); pal_m[3] = 6'h11;
        wr(8'h04); wr(8'h12); pal_m[4] = 6'h12;
        wr(8'h03);
        rd_check("R3 alternate entry3", 8'h11);
        // R7: reads do not toggle: next write still data
        rd_check("R7 second read same", 8'h11);
        wr(8'h33); pal_m[3] = 6'h33;
        rd_check("R7 read did not toggle", 8'h33);
        // R7: rdata holds without cpu_rd
        stat(); wr(8'h04);
        repeat (3) @(negedge clk);
        check("R7 rdata hold", cpu_rdata, 8'h33);

        // R2: status read in the same cycle as a data-side write
        stat(); wr(8'h06);
        cyc(1'b1, 8'h21, 1'b0, 1'b1); pal_m[6] = 6'h21;
        wr(8'h07); wr(8'h22); pal_m[7] = 6'h22;
        stat(); wr(8'h06);
        rd_check("R2 same-cycle write used old phase", 8'h21);
        stat(); wr(8'h07);
        rd_check("R2 toggle cleared after", 8'h22);

        // R4: reserved index bits ignored, selector 0x08 with bits 7:6 set
        stat(); wr(8'hC8);
        rd_check("R4 reserved index bits dropped", {2'b00, pal_m[8]});

        // R8: out-of-range selectors
        stat(); wr(8'h12); wr(8'h3F);
        rd_check("R8 out-of-range read", 0);
        stat(); wr(8'h02);
        rd_check("R8 entry2 untouched", {2'b00, pal_m[2]});

        // R10: source bit 0, pixel uses selector low bits
        stat(); wr(8'h09); pix_val = 4'h1;
        @(negedge clk);
        check("R10 pix from selector", pix_color, pal_m[9]);
        stat(); wr(8'h1B); pix_val = 4'h0;
        @(negedge clk);
        check("R10 pix from selector low bits", pix_color, pal_m[11]);

        // R6 / R7: source bit 1 blocks CPU access
        stat(); wr(8'h23); wr(8'h15);
        rd_check("R7 blocked read zero", 0);
        // R9: pixel sweep over all widths and values
        for (int m = 0; m < 4; m++) begin
            for (int v = 0; v < 16; v++) begin
                pix_mode = 2'(m); pix_val = 4'(v);
                @(posedge clk);
                @(negedge clk);
                check("R9 pixel lookup", pix_color, pix_exp(m, v));
            end
        end
        // R6: blocked write left entry 3 unchanged (via pixel port)
        pix_mode = 2'b10; pix_val = 4'h3;
        @(posedge clk); @(negedge clk);
        check("R6 blocked write ignored", pix_color, pal_m[3]);
        // R6: toggle still advanced: next write is index
        wr(8'h03);
        rd_check("R6 toggle advanced", {2'b00, pal_m[3]});

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule